// File: doc/BRIEF.md
# Fully Associative Write-Back Data Cache Controller

This block is a small data cache that sits between a processor port and a memory port that moves one whole line at a time. The processor port carries 32-bit word reads and writes on a 32-bit byte address. Lines are 64 bytes wide. The cache has no index field, so every entry is compared against the upper 26 address bits in parallel. Each entry keeps a valid bit, a tag and a dirty bit next to its 512-bit line.

A request that hits completes in the same cycle. A request that misses starts a miss sequence. The controller first picks a victim entry. If the victim holds modified data, the controller writes that line back to memory. It then fetches the requested line and installs it. Writes allocate on a miss: the fetched line is merged with the written word and marked dirty. A read miss installs the line clean. During the whole sequence the processor keeps its request asserted and stable. When the sequence ends, the held request hits and completes.

Top module: `wa_cache`

## Requirements
- R1: A request whose address bits [31:6] equal the tag of a valid entry raises `cpu_ready` in the same cycle and starts no memory request.
- R2: On a read hit, `cpu_rdata` carries word number addr[5:2] of the line, where word k occupies line bits [32k+31:32k].
- R3: A write hit replaces only word addr[5:2] of the line, leaves the other 15 words unchanged, and marks the line dirty.
- R4: On a miss, `cpu_ready` stays low and `mem_req` rises in the next cycle. Both hold until the line is installed, and the request then completes as a hit.
- R5: The victim is the lowest-numbered invalid entry if one exists. Otherwise it is the entry named by a round-robin pointer that starts at 0 and advances by one, wrapping, each time a valid entry is evicted.
- R6: If the victim is valid and dirty, its line is written back first: `mem_we`=1, `mem_addr`={victim tag, 6'b0}, `mem_wline` = the victim line. The fetch follows.
- R7: The fetch drives `mem_we`=0 and `mem_addr`={request addr[31:6], 6'b0}. Each memory request holds `mem_req` high until `mem_done` pulses, and `mem_addr` is always line aligned.
- R8: A write miss installs the fetched line with the written word merged in and marks it dirty, so a later eviction writes it back.
- R9: A read miss installs the line clean, so a later eviction of that line performs no writeback.
- R10: Reset clears every valid and dirty bit and returns the pointer to 0. While reset is applied, `mem_req` and `cpu_ready` are low, and after reset every request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with ready |
| mem_req | output | 1 | Memory line request, held until done |
| mem_we | output | 1 | 1 = line writeback, 0 = line fetch |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wline | output | 512 | Line written back |
| mem_rline | input | 512 | Fetched line, valid with done |
| mem_done | input | 1 | One-cycle completion pulse |

## Verification
A sequence of accesses over six lines first fills a four-entry cache through its invalid entries. It then forces evictions while the victims alternate between dirty and clean. The count of writebacks per miss shows apart the round-robin order, write-allocate dirtiness and read-miss cleanliness. Reading back words that were written before an eviction shows that the writeback address and the merge are correct. Directed accesses after a mid-run reset show that the valid bits are cleared, and that a write hit keeps the neighbouring words of its line.

// File: rtl/wa_cache_pkg.sv
package wa_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FETCH = 2'd2
  } miss_st_t;
endpackage

// File: rtl/wa_tag_store.sv
module wa_tag_store #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 26,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [TAG_W-1:0]   rd_tag,
  output logic               rd_dirty,
  output logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic               fill_dirty,
  input  logic               mark_en,
  input  logic [IDX_W-1:0]   mark_idx
);
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] drt_q;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit       = |match;
  assign rd_tag    = tag_q[rd_idx];
  assign rd_dirty  = vld_q[rd_idx] & drt_q[rd_idx];
  assign valid_vec = vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      drt_q <= '0;
    end else if (fill_en) begin
      vld_q[fill_idx] <= 1'b1;
      drt_q[fill_idx] <= fill_dirty;
    end else if (mark_en) begin
      drt_q[mark_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end
endmodule

// File: rtl/wa_victim_pick.sv
module wa_victim_pick #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               all_valid
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign all_valid  = &valid_vec;
  assign victim_idx = all_valid ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (advance && all_valid) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/wa_miss_fsm.sv
module wa_miss_fsm
  import wa_cache_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     vic_dirty,
  input  logic     mem_done,
  output miss_st_t state,
  output logic     busy,
  output logic     fill_now
);
  miss_st_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = vic_dirty ? ST_WBACK : ST_FETCH;
      ST_WBACK: if (mem_done) state_d = ST_FETCH;
      ST_FETCH: if (mem_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state    = state_q;
  assign busy     = (state_q != ST_IDLE);
  assign fill_now = (state_q == ST_FETCH) && mem_done;
endmodule

// File: rtl/wa_cache.sv
module wa_cache
  import wa_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [WORD_W-1:0]       cpu_wdata,
  output logic                    cpu_ready,
  output logic [WORD_W-1:0]       cpu_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LINE_BYTES*8-1:0] mem_wline,
  input  logic [LINE_BYTES*8-1:0] mem_rline,
  input  logic                    mem_done
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int OFFS_W = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - OFFS_W;
  localparam int WB_W   = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFFS_W - WB_W;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFFS_W];
  endfunction

  function automatic logic [WSEL_W-1:0] wsel_of(input logic [ADDR_W-1:0] a);
    return a[OFFS_W-1:WB_W];
  endfunction

  function automatic logic [WORD_W-1:0] get_word(input logic [LINE_W-1:0] ln,
                                                 input logic [WSEL_W-1:0] s);
    return ln[s*WORD_W +: WORD_W];
  endfunction

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] ln,
                                                 input logic [WSEL_W-1:0] s,
                                                 input logic [WORD_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = ln;
    r[s*WORD_W +: WORD_W] = w;
    return r;
  endfunction

  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [TAG_W-1:0]   req_tag;
  logic [WSEL_W-1:0]  req_wsel;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   vic_q;
  logic [IDX_W-1:0]   vic_pick;
  logic [TAG_W-1:0]   vic_tag;
  logic               vic_dirty_q;
  logic               vic_dirty_pick;
  logic [ENTRIES-1:0] valid_vec;
  logic               all_valid;
  logic               miss_start;
  logic               miss_busy;
  logic               fill_now;
  logic               wr_hit;
  logic               idle;
  miss_st_t           st;
  logic               unused_bits;

  assign unused_bits = ^{cpu_addr[WB_W-1:0], vic_dirty_q, all_valid};
  assign req_tag     = tag_of(cpu_addr);
  assign req_wsel    = wsel_of(cpu_addr);
  assign idle        = (st == ST_IDLE);
  assign cpu_ready   = idle && cpu_req && hit;
  assign miss_start  = idle && cpu_req && !hit;
  assign wr_hit      = cpu_ready && cpu_we;
  assign cpu_rdata   = get_word(line_q[hit_idx], req_wsel);

  // The victim's dirty bit is read through the tag store's read port,
  // which sees the picked index while idle and the held one afterwards.
  wa_tag_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .lk_tag(req_tag), .hit(hit), .hit_idx(hit_idx),
    .rd_idx(idle ? vic_pick : vic_q), .rd_tag(vic_tag), .rd_dirty(vic_dirty_pick),
    .valid_vec(valid_vec), .fill_en(fill_now), .fill_idx(vic_q),
    .fill_tag(req_tag), .fill_dirty(cpu_we), .mark_en(wr_hit), .mark_idx(hit_idx)
  );

  wa_victim_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .advance(miss_start),
    .victim_idx(vic_pick), .all_valid(all_valid)
  );

  wa_miss_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(miss_start), .vic_dirty(vic_dirty_pick),
    .mem_done(mem_done), .state(st), .busy(miss_busy), .fill_now(fill_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_q       <= '0;
      vic_dirty_q <= 1'b0;
    end else if (miss_start) begin
      vic_q       <= vic_pick;
      vic_dirty_q <= vic_dirty_pick;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_now) begin
      line_q[vic_q] <= cpu_we ? put_word(mem_rline, req_wsel, cpu_wdata) : mem_rline;
    end else if (wr_hit) begin
      line_q[hit_idx] <= put_word(line_q[hit_idx], req_wsel, cpu_wdata);
    end
  end

  assign mem_req   = miss_busy;
  assign mem_we    = (st == ST_WBACK);
  assign mem_addr  = (st == ST_WBACK) ? {vic_tag, {OFFS_W{1'b0}}}
                                      : {req_tag, {OFFS_W{1'b0}}};
  assign mem_wline = line_q[vic_q];
endmodule

// File: rtl/wa_cache_chk.sv
module wa_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              miss_busy,
  input logic              fill_now
);
  // R4
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_busy |-> !cpu_ready);
  // R1
  ready_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_done) |=> mem_req);
  // R7
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFFS_W-1:0] == '0));
  // R6
  wb_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_done) |=> (mem_req && !mem_we));
  // R4
  fill_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_now |=> !mem_req);
endmodule

bind wa_cache wa_cache_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_done(mem_done), .mem_addr(mem_addr),
  .miss_busy(miss_busy), .fill_now(fill_now)
);

// File: tb/wa_cache_bench.sv
`timescale 1ns/1ps
module wa_cache_bench;
  localparam int LAT = 3;
  localparam int NV  = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
  logic         cpu_ready;
  logic [31:0]  cpu_rdata;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [511:0] mem_wline;
  logic [511:0] mem_rline = '0;
  logic         mem_done = 1'b0;

  int checks = 0, errors = 0;
  int wr_ops = 0, rd_ops = 0;
  logic [31:0]  shadow [256];
  logic [511:0] mem_lines [16];

  always #5 clk = ~clk;

  wa_cache u_wa_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wline(mem_wline), .mem_rline(mem_rline),
    .mem_done(mem_done)
  );

  function automatic logic [31:0] init_word(input int idx);
    return {16'hC0DE, 8'h00, 8'(idx)};
  endfunction

  function automatic logic [31:0] mk_addr(input int ln, input int wd);
    return {22'h0, 4'(ln), 4'(wd), 2'b00};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Line memory model: one request at a time, done after LAT cycles.
  initial begin
    for (int l = 0; l < 16; l++)
      for (int w = 0; w < 16; w++) mem_lines[l][w*32 +: 32] = init_word(l*16 + w);
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        repeat (LAT - 1) @(negedge clk);
        if (mem_we) begin
          mem_lines[mem_addr[9:6]] = mem_wline;
          wr_ops++;
        end else begin
          mem_rline = mem_lines[mem_addr[9:6]];
          rd_ops++;
        end
        mem_done = 1'b1;
        @(negedge clk);
        mem_done = 1'b0;
      end
    end
  end

  task automatic do_op(input logic we, input int ln, input int wd, input logic [31:0] wdat,
                       output logic was_hit, output logic [31:0] rdat);
    int lat;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = mk_addr(ln, wd); cpu_wdata = wdat;
    #1;
    lat = 0;
    while (!cpu_ready && lat < 60) begin
      @(negedge clk); #1;
      lat++;
    end
    if (lat >= 60) begin
      errors++;
      $display("FAIL R4 request never completed: actual stuck expected ready");
    end
    was_hit = (lat == 0);
    rdat = cpu_rdata;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    if (we) shadow[ln*16 + wd] = wdat;
  endtask

  // {we, line[3:0], word[3:0], wdata[31:0], exp_hit, exp_writeback}
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 4'd1, 4'd0, 32'h0,        1'b0, 1'b0},
    {1'b1, 4'd1, 4'd3, 32'h11111111, 1'b1, 1'b0},
    {1'b0, 4'd1, 4'd3, 32'h0,        1'b1, 1'b0},
    {1'b1, 4'd2, 4'd1, 32'h22222222, 1'b0, 1'b0},
    {1'b0, 4'd3, 4'd0, 32'h0,        1'b0, 1'b0},
    {1'b0, 4'd4, 4'd5, 32'h0,        1'b0, 1'b0},
    {1'b0, 4'd5, 4'd2, 32'h0,        1'b0, 1'b1},
    {1'b0, 4'd1, 4'd3, 32'h0,        1'b0, 1'b1},
    {1'b0, 4'd2, 4'd1, 32'h0,        1'b0, 1'b0},
    {1'b1, 4'd4, 4'd5, 32'h44444444, 1'b1, 1'b0},
    {1'b0, 4'd6, 4'd0, 32'h0,        1'b0, 1'b1},
    {1'b0, 4'd4, 4'd5, 32'h0,        1'b0, 1'b0},
    {1'b0, 4'd5, 4'd7, 32'h0,        1'b0, 1'b0}
  };

  initial begin
    logic h;
    logic [31:0] rd;
    int w0, r0;
    for (int i = 0; i < 256; i++) shadow[i] = init_word(i);

    // R10: reset state with a request already present
    cpu_req = 1'b1; cpu_addr = mk_addr(1, 0);
    repeat (3) @(negedge clk);
    check("R10", "mem_req in reset", {31'b0, mem_req}, 32'd0);
    check("R10", "cpu_ready in reset", {31'b0, cpu_ready}, 32'd0);
    cpu_req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "mem_req idle after reset", {31'b0, mem_req}, 32'd0);

    // Table walk: R1 hits, R4 misses, R5/R6/R8/R9 writeback pattern, R2 data
    for (int v = 0; v < NV; v++) begin
      w0 = wr_ops; r0 = rd_ops;
      do_op(VEC[v][42], int'(VEC[v][41:38]), int'(VEC[v][37:34]), VEC[v][33:2], h, rd);
      check(VEC[v][1] ? "R1" : "R4", $sformatf("vec %0d hit", v), {31'b0, h}, {31'b0, VEC[v][1]});
      check(VEC[v][0] ? "R6" : "R9", $sformatf("vec %0d writebacks", v), wr_ops - w0, {31'b0, VEC[v][0]});
      check("R7", $sformatf("vec %0d fetches", v), rd_ops - r0, {31'b0, !VEC[v][1]});
      if (!VEC[v][42])
        check("R2", $sformatf("vec %0d rdata", v), rd,
              shadow[int'(VEC[v][41:38])*16 + int'(VEC[v][37:34])]);
    end

    // R8: write-miss merged word survived a writeback and refetch
    check("R8", "merged word in memory line 2", mem_lines[2][1*32 +: 32], 32'h22222222);

    // R1: line 2 still cached
    w0 = wr_ops; r0 = rd_ops;
    do_op(1'b0, 2, 1, 32'h0, h, rd);
    check("R1", "line 2 hit before reset", {31'b0, h}, 32'd1);
    check("R1", "no memory traffic on hit", (wr_ops - w0) + (rd_ops - r0), 32'd0);

    // R10: reset while idle invalidates everything
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    w0 = wr_ops;
    do_op(1'b0, 2, 1, 32'h0, h, rd);
    check("R10", "line 2 misses after reset", {31'b0, h}, 32'd0);
    check("R10", "no writeback after reset", wr_ops - w0, 32'd0);
    check("R2", "refetched word", rd, 32'h22222222);

    // R3: write hit keeps neighbours
    do_op(1'b1, 2, 2, 32'h33333333, h, rd);
    check("R3", "write hit", {31'b0, h}, 32'd1);
    do_op(1'b0, 2, 1, 32'h0, h, rd);
    check("R3", "neighbour word kept", rd, 32'h22222222);
    do_op(1'b0, 2, 2, 32'h0, h, rd);
    check("R3", "written word", rd, 32'h33333333);
    do_op(1'b0, 2, 15, 32'h0, h, rd);
    check("R2", "last word of line", rd, shadow[2*16 + 15]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule